// File: doc/BRIEF.md
# Dual-Lane Fractional Saturating Multiplier

This block multiplies two 64-bit operands as two independent 32-bit lanes, using fractional (Q-format) arithmetic. The product of each lane is doubled. The doubled value is then clamped to a 32-bit range, which is either signed or unsigned. In halfword mode, each lane takes one 16-bit half from each operand's 32-bit word. A separate select for each operand chooses which half. In word mode, each lane multiplies the whole 32-bit words. The doubled 64-bit intermediate wraps, so its top sign bit is lost.

The unit has a single register stage. The lane results, the overflow flags and a valid strobe appear one clock after an input is accepted. When the accumulator write enable is set together with a valid input, the same saturated results are also loaded into a separately visible 64-bit accumulator. Otherwise the accumulator keeps its value. The unit is used as the multiply step of a SIMD datapath that wants saturated fractional products and a running accumulator image.

Top module: `frac_dual_mul`

## Requirements
- R1: When `mode` is 0, each lane picks bits 31:16 of its operand word if that operand's half select is 1, and bits 15:0 if it is 0. The two halves are sign-extended, multiplied as signed numbers, and the product is doubled to form a 64-bit intermediate.
- R2: When `mode` is 1, each lane sign-extends both 32-bit words, multiplies them, and doubles the product modulo 2^64. A bit shifted out of bit 63 is discarded, so 0x80000000 times 0x80000000 gives an intermediate of -2^63.
- R3: When `sat_uns` is 0, an intermediate below -2^31 or above 2^31-1 sets the lane's overflow flag. The lane result is then 0x80000000 if bit 63 of the intermediate is set, and 0x7FFFFFFF if it is clear.
- R4: When `sat_uns` is 1, an intermediate that is negative or above 2^32-1 sets the lane's overflow flag. The lane result is then 0x00000000 if it is negative, and 0xFFFFFFFF otherwise.
- R5: When a lane does not saturate, its overflow flag is 0 and its result is bits 31:0 of the intermediate.
- R6: Lane 0 uses operand bits 63:32 and drives `result[63:32]` and `ovf[0]`. Lane 1 uses bits 31:0 and drives `result[31:0]` and `ovf[1]`. The two lanes do not affect each other.
- R7: `result`, `ovf` and `res_valid` update on the clock edge that accepts `in_valid`. A cycle without `in_valid` drives `res_valid` low and leaves `result` and `ovf` unchanged.
- R8: When `in_valid` and `acc_we` are both set, the accumulator loads {lane 0 result, lane 1 result} on the same edge. Otherwise it holds its value.
- R9: A synchronous active-low reset clears `acc`, `result`, `ovf` and `res_valid`, and it overrides a valid input on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 64 | First operand, two 32-bit lanes |
| op_b | input | 64 | Second operand, two 32-bit lanes |
| mode | input | 1 | 0 = halfword 16x16, 1 = word 32x32 |
| hsel_a | input | 1 | Half select for op_a in halfword mode (1 = bits 31:16) |
| hsel_b | input | 1 | Half select for op_b in halfword mode (1 = bits 31:16) |
| sat_uns | input | 1 | 0 = signed 32-bit clamp, 1 = unsigned 32-bit clamp |
| acc_we | input | 1 | Load the accumulator with this input's results |
| result | output | 64 | Registered saturated lane results |
| ovf | output | 2 | Registered overflow flag per lane |
| res_valid | output | 1 | Result registered this cycle |
| acc | output | 64 | Accumulator value |

## Verification
Several properties are checked on every cycle by the assertions:
- The valid strobe follows the input one cycle later.
- `result` and `ovf` hold when no input arrives.
- The accumulator either loads exactly the new result or stays stable.
- A flagged lane always carries one of the two clamp constants of its range, and the lane's overflow flag sets only when that saturation occurs.

The assertions cannot show that a product is arithmetically right. Three cases are therefore left to the bench scenarios: the half selection, the wrap of bit 63 in word mode, and the boundary products such as -1.0 times -1.0 in halfword mode. The bench compares these against its own fractional model.

// File: rtl/frac_mul_pkg.sv
// Package: shared mode encoding and default geometry for the dual-lane
// fractional multiplier. Assumes two lanes packed high-to-low in a word.
package frac_mul_pkg;
    typedef enum logic {
        MODE_HALF = 1'b0,
        MODE_WORD = 1'b1
    } mul_mode_e;

    localparam int DEF_LANE_W = 32;
    localparam int DEF_LANES  = 2;
endpackage

// File: rtl/frac_lane_mul.sv
// Module: one lane's fractional multiply. Picks halfwords or words, sign-
// extends, multiplies signed and doubles. Assumes LANE_W is even; the
// doubled intermediate is 2*LANE_W bits and wraps, so the top sign bit
// may be lost.
module frac_lane_mul
    import frac_mul_pkg::*;
#(
    parameter int LANE_W = DEF_LANE_W
) (
    input  logic [LANE_W-1:0]   a_word,
    input  logic [LANE_W-1:0]   b_word,
    input  mul_mode_e           mode,
    input  logic                hsel_a,
    input  logic                hsel_b,
    output logic [2*LANE_W-1:0] inter
);
    localparam int HW = LANE_W / 2;
    localparam int PW = 2 * LANE_W;

    logic [HW-1:0]        half_a, half_b;
    logic signed [LANE_W-1:0] ext_a, ext_b;
    logic signed [PW-1:0] prod;

    // Select the requested halfword of each operand word.
    always_comb begin
        half_a = hsel_a ? a_word[LANE_W-1:HW] : a_word[HW-1:0];
        half_b = hsel_b ? b_word[LANE_W-1:HW] : b_word[HW-1:0];
    end

    // Form sign-extended lane-width factors for the selected mode.
    always_comb begin
        if (mode == MODE_WORD) begin
            ext_a = a_word;
            ext_b = b_word;
        end else begin
            ext_a = {{(LANE_W-HW){half_a[HW-1]}}, half_a};
            ext_b = {{(LANE_W-HW){half_b[HW-1]}}, half_b};
        end
    end

    // Signed multiply at full width, then double, discarding the carry-out.
    always_comb begin
        prod  = ext_a * ext_b;
        inter = {prod[PW-2:0], 1'b0};
    end
endmodule

// File: rtl/frac_lane_sat.sv
// Module: clamps a lane's 2*LANE_W-bit intermediate to a signed or unsigned
// LANE_W-bit range. The clamp constant is chosen by the intermediate's sign bit.
// Assumes the intermediate is a two's-complement value.
module frac_lane_sat #(
    parameter int LANE_W = 32
) (
    input  logic [2*LANE_W-1:0] inter,
    input  logic                uns,
    output logic [LANE_W-1:0]   res,
    output logic                ovf
);
    localparam int PW = 2 * LANE_W;

    logic neg, s_ovf, u_ovf;
    logic [LANE_W-1:0] s_clamp, u_clamp;

    // Detect the out-of-range conditions for both ranges.
    always_comb begin
        neg   = inter[PW-1];
        s_ovf = (|inter[PW-1:LANE_W-1]) && !(&inter[PW-1:LANE_W-1]);
        u_ovf = neg || (|inter[PW-1:LANE_W]);
    end

    // Pick the clamp constant from the sign of the intermediate.
    always_comb begin
        s_clamp = neg ? {1'b1, {(LANE_W-1){1'b0}}} : {1'b0, {(LANE_W-1){1'b1}}};
        u_clamp = neg ? '0 : '1;
    end

    // Pass the low word through, or replace it when the range is exceeded.
    always_comb begin
        ovf = uns ? u_ovf : s_ovf;
        if (!ovf)
            res = inter[LANE_W-1:0];
        else
            res = uns ? u_clamp : s_clamp;
    end
endmodule

// File: rtl/frac_dual_mul.sv
// Module: top of the dual-lane fractional saturating multiplier. Lane 0 sits
// in the upper word. Results and flags are registered one cycle after a valid
// input; the accumulator optionally loads the same results. Assumes a
// synchronous active-low reset.
module frac_dual_mul
    import frac_mul_pkg::*;
#(
    parameter int LANE_W = DEF_LANE_W,
    parameter int LANES  = DEF_LANES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*LANE_W-1:0] op_a,
    input  logic [LANES*LANE_W-1:0] op_b,
    input  logic                    mode,
    input  logic                    hsel_a,
    input  logic                    hsel_b,
    input  logic                    sat_uns,
    input  logic                    acc_we,
    output logic [LANES*LANE_W-1:0] result,
    output logic [LANES-1:0]        ovf,
    output logic                    res_valid,
    output logic [LANES*LANE_W-1:0] acc
);
    localparam int DW = LANES * LANE_W;
    localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};

    logic [DW-1:0]    res_nxt;
    logic [LANES-1:0] ovf_nxt;
    mul_mode_e        mode_e;

    assign mode_e = mul_mode_e'(mode);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = (LANES - 1 - g) * LANE_W;
        logic [2*LANE_W-1:0] inter;

        frac_lane_mul #(.LANE_W(LANE_W)) u_mul (
            .a_word (op_a[LO +: LANE_W]),
            .b_word (op_b[LO +: LANE_W]),
            .mode   (mode_e),
            .hsel_a (hsel_a),
            .hsel_b (hsel_b),
            .inter  (inter)
        );

        frac_lane_sat #(.LANE_W(LANE_W)) u_sat (
            .inter (inter),
            .uns   (sat_uns),
            .res   (res_nxt[LO +: LANE_W]),
            .ovf   (ovf_nxt[g])
        );

        // R3: a signed-clamped lane with its flag set carries a signed limit.
        a_r3_signed_clamp: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !sat_uns) |=> (!ovf[g] || result[LO +: LANE_W] == S_MAX
                                                || result[LO +: LANE_W] == S_MIN));

        // R4: an unsigned-clamped lane with its flag set carries zero or all ones.
        a_r4_unsigned_clamp: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sat_uns) |=> (!ovf[g] || result[LO +: LANE_W] == '0
                                               || result[LO +: LANE_W] == '1));
    end

    // Output register: capture lane results and flags on a valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            ovf       <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                result <= res_nxt;
                ovf    <= ovf_nxt;
            end
        end
    end

    // Accumulator: load the packed lane results when writing is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (in_valid && acc_we)
            acc <= res_nxt;
    end

    // R7: the valid strobe follows the input one cycle later.
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    // R7: an idle cycle keeps the outputs and drops the strobe.
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && $stable(result) && $stable(ovf)));

    // R8: a write loads the same value that the result register takes.
    a_r8_acc_load: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_we) |=> (acc == result));

    // R8: without a write the accumulator holds its value.
    a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && acc_we) |=> $stable(acc));
endmodule

// File: tb/sim_frac_dual_mul.sv
module sim_frac_dual_mul;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        mode = 1'b0, hsel_a = 1'b0, hsel_b = 1'b0;
    logic        sat_uns = 1'b0, acc_we = 1'b0;
    logic [63:0] result, acc;
    logic [1:0]  ovf;
    logic        res_valid;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [63:0] acc_exp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_dual_mul u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .mode(mode), .hsel_a(hsel_a), .hsel_b(hsel_b), .sat_uns(sat_uns),
        .acc_we(acc_we), .result(result), .ovf(ovf), .res_valid(res_valid), .acc(acc)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bench model of one lane: returns {ovf, result}.
    function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic m, input logic ha, input logic hb,
                                          input logic uns);
        longint x, y, p;
        logic [15:0] sa, sb;
        logic o;
        logic [31:0] r;
        sa = ha ? a[31:16] : a[15:0];
        sb = hb ? b[31:16] : b[15:0];
        if (m) begin
            x = longint'(signed'(a));
            y = longint'(signed'(b));
        end else begin
            x = longint'(signed'(sa));
            y = longint'(signed'(sb));
        end
        p = x * y;
        p = p <<< 1;
        if (!uns) begin
            o = (p < -64'sh80000000) || (p > 64'sh7fffffff);
            r = o ? (p < 0 ? 32'h80000000 : 32'h7fffffff) : p[31:0];
        end else begin
            o = (p < 0) || (p > 64'shffffffff);
            r = o ? (p < 0 ? 32'h0 : 32'hffffffff) : p[31:0];
        end
        return {o, r};
    endfunction

    // Apply one operation, check the registered outputs, then an idle cycle.
    task automatic op(input string req, input logic [63:0] a, input logic [63:0] b,
                      input logic m, input logic ha, input logic hb,
                      input logic uns, input logic we);
        logic [32:0] l0, l1;
        logic [63:0] held;
        l0 = model(a[63:32], b[63:32], m, ha, hb, uns);
        l1 = model(a[31:0], b[31:0], m, ha, hb, uns);
        @(negedge clk);
        op_a = a; op_b = b; mode = m; hsel_a = ha; hsel_b = hb;
        sat_uns = uns; acc_we = we; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; acc_we = 1'b0;
        if (we) acc_exp = {l0[31:0], l1[31:0]};
        chk({req, " R6 result"}, result, {l0[31:0], l1[31:0]});
        chk({req, " R6 ovf"}, {62'd0, ovf}, {62'd0, l1[32], l0[32]});
        chk({req, " R7 valid"}, {63'd0, res_valid}, 64'd1);
        chk({req, " R8 acc"}, acc, acc_exp);
        held = result;
        op_a = ~a;
        @(negedge clk);
        chk("R7 idle hold", result, held);
        chk("R7 idle valid", {63'd0, res_valid}, 64'd0);
        chk("R8 acc hold", acc, acc_exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk("R9 reset result", result, 64'd0);
        chk("R9 reset acc", acc, 64'd0);
        chk("R9 reset flags", {61'd0, ovf, res_valid}, 64'd0);

        // R1: low halves 0x4000*0x4000 -> 0x20000000; R5 no saturation
        op("R1 R5 low halves", 64'h0000_4000_0000_4000, 64'h0000_4000_0000_4000, 0, 0, 0, 0, 1);
        // R1: high halves selected per operand
        op("R1 high halves", 64'h1234_0003_FFFE_0005, 64'h0007_FFFF_0002_1111, 0, 1, 0, 0, 1);
        // R3: -1.0 * -1.0 saturates to positive limit
        op("R3 half minus one squared", 64'h8000_8000_0000_8000, 64'h8000_8000_0000_8000, 0, 0, 0, 0, 1);
        // R4: negative product under unsigned clamp -> 0
        op("R4 unsigned negative", 64'h0000_FFFF_0000_0001, 64'h0000_0001_0000_0001, 0, 0, 0, 1, 1);
        // R4: -1.0 squared doubled = 2^31 fits unsigned
        op("R4 unsigned fits", 64'h0000_8000_0000_7FFF, 64'h0000_8000_0000_7FFF, 0, 0, 0, 1, 0);
        // R2: 0x80000000 squared wraps to -2^63 -> signed negative limit
        op("R2 word wrap", 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 1, 0, 0, 0, 1);
        // R2: wrap under unsigned clamp -> 0
        op("R2 word wrap unsigned", 64'h8000_0000_FFFF_FFFF, 64'h8000_0000_FFFF_FFFF, 1, 0, 0, 1, 1);
        // R3: large word product, positive and negative
        op("R3 word large", 64'h0001_0000_FFFF_0000, 64'h0001_0000_0001_0000, 1, 0, 0, 0, 0);

        for (int i = 0; i < 400; i++) begin
            op("R5 random", {$urandom, $urandom}, {$urandom, $urandom},
               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        // R9: reset wins over a valid input
        @(negedge clk);
        op_a = 64'h0000_4000_0000_4000; op_b = op_a; mode = 0;
        in_valid = 1'b1; acc_we = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; acc_we = 1'b0; rst_n = 1'b1; acc_exp = '0;
        chk("R9 reset over valid result", result, 64'd0);
        chk("R9 reset over valid acc", acc, 64'd0);
        chk("R9 reset over valid flags", {61'd0, ovf, res_valid}, 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule